// File: doc/BRIEF.md
# Timestamping System Time Base

This block keeps the system time used for timestamping. The time is held as a 32-bit seconds count and a 31-bit sub-seconds count. The sub-seconds count wraps at 2^31 and carries into seconds. Each enabled cycle the time can advance by an 8-bit increment.

Two advance modes are available. In coarse mode the increment is added on every enabled cycle. In fine mode a 32-bit accumulator adds a programmable addend each enabled cycle. The increment is added to the time only in cycles where that sum overflows, so the addend trims the effective clock rate.

Software drives single-cycle command strobes:
- load the time directly from the update fields;
- add a signed update value to the time, or subtract it;
- load a new addend;
- arm a trigger against a target time.

An armed trigger fires once when the time reaches or passes the target. Firing sets a sticky status that stays until it is acknowledged.

Top module: `systime_clock`

## Requirements
- R1: After a synchronous reset the time is zero in both fields, the trigger status and armed flag are low, and the accumulator and addend are zero.
- R2: With `enable_i` high and `fine_i` low (coarse mode), each cycle without a command adds `incr_i` to the sub-seconds field, and the new time is visible after the clock edge.
- R3: The sub-seconds field counts modulo 2^31; when a sum reaches 2^31 the excess stays in sub-seconds and one is carried into seconds. Seconds wrap modulo 2^32.
- R4: With `enable_i` and `fine_i` high, the 32-bit accumulator adds the current addend every cycle. The time advances by `incr_i` only in a cycle where accumulator plus addend is 2^32 or more, and is otherwise unchanged.
- R5: With `enable_i` low, neither the time nor the accumulator moves unless a load or adjust command is given.
- R6: A pulse on `init_i` loads the time from `upd_sec_i`/`upd_sub_i` at the next edge, regardless of `enable_i`. It takes precedence over `update_i` and over advancing.
- R7: A pulse on `update_i` with `upd_neg_i` low adds the update value to the time, with carry from sub-seconds into seconds.
- R8: A pulse on `update_i` with `upd_neg_i` high subtracts the update value. A borrow is taken from seconds when the update sub-seconds exceed the current sub-seconds, and results wrap modulo 2^31 and 2^32.
- R9: In a cycle with an adjust (or load) command, the regular advance is not applied. An adjust by zero therefore leaves the time unchanged.
- R10: A pulse on `addend_load_i` stores `addend_i`. The accumulation in that same cycle still uses the previous addend; the new value is used from the next cycle on.
- R11: When the trigger is armed and the registered time is greater than or equal to the target {`tgt_sec_i`, `tgt_sub_i`} (seconds compared first), the status is set and the armed flag is cleared at the next edge. The trigger does not fire again until it is re-armed.
- R12: A pulse on `ack_i` clears the trigger status at the next edge, except when the trigger fires in that same cycle, in which case the status stays set.
- R13: A pulse on `arm_i` sets the armed flag at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Time base runs while high |
| fine_i | input | 1 | 1 = accumulator-gated fine mode, 0 = coarse mode |
| incr_i | input | INC_W (8) | Sub-seconds increment per advance |
| addend_i | input | ACC_W (32) | New addend value |
| addend_load_i | input | 1 | Strobe: store `addend_i` |
| upd_sec_i | input | 32 | Update/initial value, seconds |
| upd_sub_i | input | 31 | Update/initial value, sub-seconds |
| upd_neg_i | input | 1 | 1 = adjust subtracts the update value |
| init_i | input | 1 | Strobe: load time from update fields |
| update_i | input | 1 | Strobe: add or subtract the update value |
| tgt_sec_i | input | 32 | Target time, seconds |
| tgt_sub_i | input | 31 | Target time, sub-seconds |
| arm_i | input | 1 | Strobe: arm the target trigger |
| ack_i | input | 1 | Strobe: clear the trigger status |
| time_sec_o | output | 32 | Current seconds |
| time_sub_o | output | 31 | Current sub-seconds |
| trig_status_o | output | 1 | Sticky trigger-fired status (interrupt) |
| trig_armed_o | output | 1 | Trigger currently armed |

## Verification
Two pairs of functions can act in the same cycle. The first pair is an adjust and the regular advance. The bench issues an adjust strobe while coarse or fine advancing is active, and checks that the result is exactly the old time plus or minus the update value, with no increment. The second pair is the trigger firing and a software acknowledge. The bench holds `ack_i` in the very cycle that an armed trigger meets its target, and expects the status to stay set. A load issued together with an adjust is also checked to confirm that the load wins.

// File: rtl/systime_pkg.sv
package systime_pkg;

    localparam int SEC_W = 32;
    localparam int SUB_W = 31;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } systime_t;

    typedef enum logic [1:0] {
        TOP_HOLD    = 2'd0,
        TOP_ADVANCE = 2'd1,
        TOP_LOAD    = 2'd2,
        TOP_ADJUST  = 2'd3
    } time_op_e;

    // Sum with sub-seconds carrying into seconds at 2^SUB_W
    function automatic systime_t systime_plus(systime_t a, systime_t b);
        logic [SUB_W:0] s;
        systime_t       r;
        s     = {1'b0, a.sub} + {1'b0, b.sub};
        r.sub = s[SUB_W-1:0];
        r.sec = a.sec + b.sec + SEC_W'(s[SUB_W]);
        return r;
    endfunction

    // Difference with borrow from seconds when b.sub exceeds a.sub
    function automatic systime_t systime_minus(systime_t a, systime_t b);
        logic [SUB_W:0] d;
        systime_t       r;
        d     = {1'b0, a.sub} - {1'b0, b.sub};
        r.sub = d[SUB_W-1:0];
        r.sec = a.sec - b.sec - SEC_W'(d[SUB_W]);
        return r;
    endfunction

    // Seconds decide first, sub-seconds break ties
    function automatic logic systime_ge(systime_t a, systime_t b);
        if (a.sec != b.sec) begin
            return a.sec > b.sec;
        end
        return a.sub >= b.sub;
    endfunction

endpackage

// File: rtl/systime_accum.sv
module systime_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [ACC_W-1:0] load_val_i,
    output logic             tick_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend_q;
    logic [ACC_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
    assign tick_o  = run_i & acc_sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            addend_q <= '0;
        end else begin
            if (run_i) begin
                acc_q <= acc_sum[ACC_W-1:0];
            end
            if (load_i) begin
                addend_q <= load_val_i;
            end
        end
    end

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> acc_q == $past(acc_q));

    // R10
    addend_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> addend_q == $past(load_val_i));

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !tick_o);

endmodule

// File: rtl/systime_counter.sv
module systime_counter
    import systime_pkg::*;
#(
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             fine_i,
    input  logic             tick_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic             init_i,
    input  logic             update_i,
    input  logic             upd_neg_i,
    input  systime_t         upd_val_i,
    output systime_t         now_o
);

    systime_t now_q;
    systime_t now_d;
    systime_t step;
    time_op_e op;
    logic     advance;

    assign advance  = enable_i & (~fine_i | tick_i);
    assign step.sec = '0;
    assign step.sub = SUB_W'(incr_i);

    always_comb begin
        if (init_i) begin
            op = TOP_LOAD;
        end else if (update_i) begin
            op = TOP_ADJUST;
        end else if (advance) begin
            op = TOP_ADVANCE;
        end else begin
            op = TOP_HOLD;
        end
    end

    always_comb begin
        unique case (op)
            TOP_LOAD:    now_d = upd_val_i;
            TOP_ADJUST:  now_d = upd_neg_i ? systime_minus(now_q, upd_val_i)
                                           : systime_plus(now_q, upd_val_i);
            TOP_ADVANCE: now_d = systime_plus(now_q, step);
            default:     now_d = now_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= '0;
        end else begin
            now_q <= now_d;
        end
    end

    assign now_o = now_q;

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !init_i && !update_i) |=> now_q == $past(now_q));

    // R4
    fine_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_i && fine_i && !tick_i && !init_i && !update_i) |=> now_q == $past(now_q));

    // R6
    init_load_chk: assert property (@(posedge clk) disable iff (rst)
        init_i |=> now_q == $past(upd_val_i));

    // R9
    zero_adjust_chk: assert property (@(posedge clk) disable iff (rst)
        (update_i && !init_i && upd_val_i == '0) |=> now_q == $past(now_q));

endmodule

// File: rtl/systime_trigger.sv
module systime_trigger
    import systime_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  systime_t now_i,
    input  systime_t target_i,
    input  logic     arm_i,
    input  logic     ack_i,
    output logic     armed_o,
    output logic     status_o
);

    logic armed_q;
    logic status_q;
    logic reached;
    logic fire;

    assign reached = systime_ge(now_i, target_i);
    assign fire    = armed_q & reached;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            status_q <= 1'b0;
        end else begin
            status_q <= fire | (status_q & ~ack_i);
            if (arm_i) begin
                armed_q <= 1'b1;
            end else if (fire) begin
                armed_q <= 1'b0;
            end
        end
    end

    assign armed_o  = armed_q;
    assign status_o = status_q;

    // R11
    fire_once_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && reached && !arm_i) |=> (!armed_q && status_q));

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !status_q) |=> !status_q);

    // R12
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !(armed_q && reached)) |=> !status_q);

    // R13
    arm_set_chk: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> armed_q);

endmodule

// File: rtl/systime_clock.sv
module systime_clock
    import systime_pkg::*;
#(
    parameter int INC_W = 8,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             fine_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic [ACC_W-1:0] addend_i,
    input  logic             addend_load_i,
    input  logic [SEC_W-1:0] upd_sec_i,
    input  logic [SUB_W-1:0] upd_sub_i,
    input  logic             upd_neg_i,
    input  logic             init_i,
    input  logic             update_i,
    input  logic [SEC_W-1:0] tgt_sec_i,
    input  logic [SUB_W-1:0] tgt_sub_i,
    input  logic             arm_i,
    input  logic             ack_i,
    output logic [SEC_W-1:0] time_sec_o,
    output logic [SUB_W-1:0] time_sub_o,
    output logic             trig_status_o,
    output logic             trig_armed_o
);

    systime_t upd_val;
    systime_t target;
    systime_t now;
    logic     fine_tick;

    assign upd_val.sec = upd_sec_i;
    assign upd_val.sub = upd_sub_i;
    assign target.sec  = tgt_sec_i;
    assign target.sub  = tgt_sub_i;

    systime_accum #(
        .ACC_W (ACC_W)
    ) accum_i (
        .clk        (clk),
        .rst        (rst),
        .run_i      (enable_i & fine_i),
        .load_i     (addend_load_i),
        .load_val_i (addend_i),
        .tick_o     (fine_tick)
    );

    systime_counter #(
        .INC_W (INC_W)
    ) counter_i (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable_i),
        .fine_i    (fine_i),
        .tick_i    (fine_tick),
        .incr_i    (incr_i),
        .init_i    (init_i),
        .update_i  (update_i),
        .upd_neg_i (upd_neg_i),
        .upd_val_i (upd_val),
        .now_o     (now)
    );

    systime_trigger trigger_i (
        .clk      (clk),
        .rst      (rst),
        .now_i    (now),
        .target_i (target),
        .arm_i    (arm_i),
        .ack_i    (ack_i),
        .armed_o  (trig_armed_o),
        .status_o (trig_status_o)
    );

    assign time_sec_o = now.sec;
    assign time_sub_o = now.sub;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (time_sec_o == '0 && time_sub_o == '0 && !trig_status_o && !trig_armed_o));

endmodule

// File: tb/systime_clock_tb_top.sv
module systime_clock_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        en, fine;
    logic [7:0]  incr;
    logic [31:0] addend_v;
    logic        addend_s;
    logic [31:0] upd_sec;
    logic [30:0] upd_sub;
    logic        upd_neg, init_s, upd_s;
    logic [31:0] tgt_sec;
    logic [30:0] tgt_sub;
    logic        arm_s, ack_s;
    logic [31:0] o_sec;
    logic [30:0] o_sub;
    logic        o_stat, o_armed;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [62:0] m_time;
    logic [31:0] m_acc, m_add;
    logic        m_armed, m_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    systime_clock dut_i (
        .clk(clk), .rst(rst), .enable_i(en), .fine_i(fine), .incr_i(incr),
        .addend_i(addend_v), .addend_load_i(addend_s),
        .upd_sec_i(upd_sec), .upd_sub_i(upd_sub), .upd_neg_i(upd_neg),
        .init_i(init_s), .update_i(upd_s),
        .tgt_sec_i(tgt_sec), .tgt_sub_i(tgt_sub), .arm_i(arm_s), .ack_i(ack_s),
        .time_sec_o(o_sec), .time_sub_o(o_sub),
        .trig_status_o(o_stat), .trig_armed_o(o_armed)
    );

    task automatic model_next();
        logic [32:0] s;
        logic [62:0] u;
        logic        tk, fire;
        u    = {upd_sec, upd_sub};
        fire = m_armed && (m_time >= {tgt_sec, tgt_sub});
        s    = {1'b0, m_acc} + {1'b0, m_add};
        tk   = en && fine && s[32];
        if (init_s)           m_time = u;
        else if (upd_s)       m_time = upd_neg ? m_time - u : m_time + u;
        else if (en && (!fine || tk)) m_time = m_time + 63'(incr);
        if (en && fine)   m_acc = s[31:0];
        if (addend_s)     m_add = addend_v;
        m_stat  = fire | (m_stat & ~ack_s);
        m_armed = arm_s ? 1'b1 : (fire ? 1'b0 : m_armed);
    endtask

    task automatic check(input string tag);
        n_checks++;
        if ({o_sec, o_sub} !== m_time || o_stat !== m_stat || o_armed !== m_armed) begin
            n_fail++;
            $display("FAIL %s: got sec=%0h sub=%0h st=%b arm=%b, expected sec=%0h sub=%0h st=%b arm=%b",
                     tag, o_sec, o_sub, o_stat, o_armed,
                     m_time[62:31], m_time[30:0], m_stat, m_armed);
        end
    endtask

    task automatic step(input string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        init_s = 0; upd_s = 0; addend_s = 0; arm_s = 0; ack_s = 0;
        check(tag);
    endtask

    task automatic load_time(input logic [31:0] s, input logic [30:0] ss, input string tag);
        upd_sec = s; upd_sub = ss; init_s = 1;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        rst = 1; en = 0; fine = 0; incr = 0; addend_v = 0; addend_s = 0;
        upd_sec = 0; upd_sub = 0; upd_neg = 0; init_s = 0; upd_s = 0;
        tgt_sec = 32'hFFFF_FFFF; tgt_sub = '1; arm_s = 0; ack_s = 0;
        m_time = 0; m_acc = 0; m_add = 0; m_armed = 0; m_stat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset state");

        // R5: disabled, nothing moves
        incr = 8'd9;
        for (int i = 0; i < 4; i++) step("R5 disabled hold");

        // R2/R3: coarse sweep of every increment across the sub-second wrap
        en = 1;
        for (int k = 0; k < 256; k++) begin
            incr = 8'(k);
            load_time(32'(k) + 32'd5, 31'h7FFF_FFFF - 31'(k), "R6 load");
            for (int c = 0; c < 3; c++) step("R2 R3 coarse advance/carry");
        end
        load_time(32'hFFFF_FFFF, 31'h7FFF_FFF0, "R6 load");
        incr = 8'hFF;
        for (int c = 0; c < 3; c++) step("R3 seconds wrap");

        // R4/R10: fine mode with a range of addends
        fine = 1; incr = 8'd7;
        for (int k = 0; k < 16; k++) begin
            addend_v = 32'(k) * 32'h1111_1111; addend_s = 1;
            step("R10 addend load");
            for (int c = 0; c < 12; c++) step("R4 fine advance");
        end
        addend_v = 32'h4000_0000; addend_s = 1;
        step("R10 addend load");
        for (int c = 0; c < 16; c++) step("R4 quarter-rate fine");
        en = 0;
        for (int c = 0; c < 5; c++) step("R5 fine disabled hold");
        en = 1;

        // R7/R8: adjust sweep, add and subtract, in both modes
        lcg = 32'h1234_5678;
        for (int i = 0; i < 128; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            upd_sec = lcg ^ 32'h5A5A_0000;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            upd_sub = lcg[30:0];
            upd_neg = i[0];
            fine = i[1];
            upd_s = 1;
            step(upd_neg ? "R8 subtract with borrow" : "R7 add with carry");
            step("R4 R2 advance after adjust");
        end
        // Borrow case spelled out: small sub minus large sub
        upd_neg = 0;
        load_time(32'd100, 31'd5, "R6 load");
        upd_sec = 32'd1; upd_sub = 31'h7000_0000; upd_neg = 1; upd_s = 1;
        step("R8 explicit borrow");
        upd_neg = 0;

        // R9: adjust and advance in the same cycle; zero adjust
        fine = 0; incr = 8'd40;
        upd_sec = 0; upd_sub = 0; upd_s = 1;
        step("R9 zero adjust suppresses advance");
        upd_sec = 32'd2; upd_sub = 31'd3; upd_s = 1;
        step("R9 adjust replaces advance");
        // R6: load wins over adjust
        upd_sec = 32'd77; upd_sub = 31'd1000; upd_s = 1; init_s = 1;
        step("R6 load beats adjust");
        en = 0;
        upd_sec = 32'd3; upd_sub = 31'd4; init_s = 1;
        step("R6 load while disabled");
        en = 1;

        // R11/R13: trigger
        incr = 8'd50;
        load_time(32'd10, 31'd100, "R6 load");
        tgt_sec = 32'd10; tgt_sub = 31'd400; arm_s = 1;
        step("R13 arm");
        for (int c = 0; c < 10; c++) step("R11 trigger fires once");
        ack_s = 1;
        step("R12 ack clears status");
        step("R12 status stays clear");
        // target already passed: fires right after arming
        tgt_sec = 32'd9; arm_s = 1;
        step("R13 arm with past target");
        ack_s = 1;
        step("R12 fire beats ack");
        step("R11 no refire");
        ack_s = 1;
        step("R12 ack");
        // target in a later second: seconds compared first
        tgt_sec = 32'd11; tgt_sub = 31'd0; arm_s = 1;
        step("R13 arm far target");
        for (int c = 0; c < 6; c++) step("R11 seconds order");
        upd_sec = 32'd1; upd_sub = 31'd0; upd_s = 1;
        step("R11 jump past target");
        step("R11 fired after jump");
        step("R11 stays fired");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule